// File: doc/BRIEF.md
# Interleaved Address Target Decoder

This block turns a physical address into the index of the unit that owns it. Depending on a level-select input, that index is either a socket (node 0 or node 1) or a memory channel. A bank of eight range rules splits the address space. Each rule has an enable, an exclusive upper limit kept at 64-byte block granularity, an interleave mode and a list of eight packed 4-bit slots. The first enabled rule whose range holds the address is chosen. A way index, formed from address bits as the rule's mode selects, then picks one slot of that rule's list.

At channel level, the slot code is a logical channel. A per-channel mapper field can then redirect it to a physical channel, steer it to a spare, or split reads across a mirrored pair. Lockstep operation bypasses the mapper.

Rules are loaded one at a time through a write port, and the whole rule is written in one cycle. A lookup is presented with a valid strobe. Its result (miss flag and target) appears registered one clock later.

Top module: `addr_target_decoder`

## Requirements
- R1: Rules are searched from index 0 upward. Rule i covers block addresses (address bits [39:6]) from the limit of rule i-1, inclusive, to its own limit, exclusive. Rule 0 starts at block 0, and the first rule that matches wins.
- R2: A rule whose enable is clear never matches. When no rule matches, the response reports a miss. After reset every rule is disabled.
- R3: In mode 0 the way index is address bits [8:6].
- R4: In mode 1 the way index is address bits [8:6] XOR address bits [18:16].
- R5: In mode 2, way bit 2 is address bit 6 and way bits [1:0] are the value of address bits [39:6] modulo 3.
- R6: A matching rule with mode 3 produces a miss.
- R7: The slot code for way w is bits [4w+1:4w] of the matching rule's 32-bit target list.
- R8: At socket level (ctl_chan_level = 0), slot code 1 gives target 0 and slot code 2 gives target 1. Any other code is a miss.
- R9: At channel level without lockstep, the logical channel is the slot code. For logical channels 0 to 2, the 3-bit mapper field at bits [3c+2:3c] is decoded. The field comes from ctl_wr_map for writes and from ctl_rd_map for reads. Code 1 gives physical channel 0, 2 gives 1, 4 gives 2, 5 gives 0 and 6 gives 1. Any other code, and logical channel 3, keep the logical channel.
- R10: A mapper code of 3 on a read selects physical channel (addr[24] XOR addr[12] XOR addr[6]). On a write, code 3 keeps the logical channel.
- R11: At channel level with ctl_lockstep set, the target is the logical channel, whatever the mapper fields hold.
- R12: A request accepted on a clock edge gives rsp_valid high with its result after that edge. A cycle with no request gives rsp_valid low, and reset clears rsp_valid.
- R13: A rule written through the configuration port on one edge is used by a request sampled on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one rule |
| cfg_idx | input | 3 | Index of the rule to write |
| cfg_enable | input | 1 | Enable of the written rule |
| cfg_limit | input | 34 | Exclusive upper limit in 64-byte blocks |
| cfg_mode | input | 2 | Way-selection mode (0 direct, 1 XOR, 2 modulo-3, 3 reserved) |
| cfg_list | input | 32 | Eight target slots at 4-bit spacing |
| ctl_chan_level | input | 1 | 0 decodes sockets, 1 decodes channels |
| ctl_lockstep | input | 1 | Bypass the channel mapper |
| ctl_rd_map | input | 9 | Mapper fields used for reads, 3 bits per logical channel |
| ctl_wr_map | input | 9 | Mapper fields used for writes, 3 bits per logical channel |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 40 | Physical address to decode |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_miss | output | 1 | No usable target for the address |
| rsp_target | output | 2 | Socket or physical channel index |

## Verification
The bench probes the address that equals a rule's limit and the block just below it. A design that closes the range at the wrong end sends that block to the wrong rule's target list. It disables a rule in the middle of the bank. A design that still honours that rule returns a hit where a miss is due, and one that skips the base chaining lets a later rule claim low addresses. For the modulo-3 mode it uses addresses near the top of the 34-bit block field, where a residue taken over too few bits gives the wrong way. For the mapper it covers the spare codes, mirrored reads against mirrored writes, and lockstep with mapper fields that would otherwise redirect. A design that applies the mirror parity to writes, or that ignores the lockstep bypass, shows up there as a wrong channel.

// File: rtl/atd_pkg.sv
package atd_pkg;
    parameter int ADDR_W   = 40;
    parameter int GRAN_LG  = 6;
    parameter int BLK_W    = ADDR_W - GRAN_LG;
    parameter int NWAY     = 8;
    parameter int SLOT_W   = 4;
    parameter int LIST_W   = NWAY * SLOT_W;
    parameter int WAY_W    = $clog2(NWAY);
    parameter int CODE_W   = 2;
    parameter int MAP_W    = 3;
    parameter int NCHAN    = 3;
    parameter int MAP_BITS = NCHAN * MAP_W;
    parameter int XOR_LSB  = 16;
    parameter int MIR_B0   = 6;
    parameter int MIR_B1   = 12;
    parameter int MIR_B2   = 24;

    typedef enum logic [1:0] {
        WAY_DIRECT = 2'd0,
        WAY_XOR    = 2'd1,
        WAY_MOD3   = 2'd2,
        WAY_RSVD   = 2'd3
    } way_mode_e;

    typedef struct packed {
        logic              en;
        logic [BLK_W-1:0]  limit;
        logic [1:0]        mode;
        logic [LIST_W-1:0] list;
    } rule_t;

    typedef struct packed {
        logic              valid;
        logic              miss;
        logic [CODE_W-1:0] target;
    } rsp_t;

    // Residue modulo 3 by summing base-4 digits (4 = 1 mod 3), then folding.
    function automatic logic [1:0] mod3_of(input logic [BLK_W-1:0] v);
        logic [BLK_W:0] p;
        logic [7:0]     s;
        logic [3:0]     s2;
        logic [2:0]     r;
        p = {1'b0, v};
        s = '0;
        for (int i = 0; i < BLK_W; i += 2) s = s + 8'(p[i +: 2]);
        s2 = 4'(s[1:0]) + 4'(s[3:2]) + 4'(s[5:4]) + 4'(s[7:6]);
        r  = 3'(s2[1:0]) + 3'(s2[3:2]);
        if (r >= 3'd3) r = r - 3'd3;
        if (r >= 3'd3) r = r - 3'd3;
        return r[1:0];
    endfunction
endpackage

// File: rtl/atd_rule_bank.sv
module atd_rule_bank
    import atd_pkg::*;
#(
    parameter int N_RULES = 8,
    parameter int IDX_W   = $clog2(N_RULES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  rule_t            wr_rule,
    input  logic [BLK_W-1:0] blk,
    output logic             hit,
    output rule_t            hit_rule
);
    rule_t            rules_d [N_RULES];
    rule_t            rules_q [N_RULES];
    logic [BLK_W-1:0] base_lim [N_RULES];
    logic [N_RULES-1:0] match;

    always_comb begin
        rules_d = rules_q;
        if (wr_en) rules_d[wr_idx] = wr_rule;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_RULES; i++) begin
            if (!rst_n) rules_q[i] <= '0;
            else        rules_q[i] <= rules_d[i];
        end
    end

    for (genvar g = 0; g < N_RULES; g++) begin : g_rule
        if (g == 0) begin : g_first
            assign base_lim[g] = '0;
        end else begin : g_chain
            assign base_lim[g] = rules_q[g-1].limit;
        end
        assign match[g] = rules_q[g].en && (blk >= base_lim[g]) && (blk < rules_q[g].limit);
    end

    // Lowest index wins.
    always_comb begin
        hit      = 1'b0;
        hit_rule = '0;
        for (int i = N_RULES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                hit_rule = rules_q[i];
            end
        end
    end

    assert_write_lands_R13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rules_q[$past(wr_idx)] == $past(wr_rule));

    assert_hit_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> hit_rule.en);
endmodule

// File: rtl/atd_way_calc.sv
module atd_way_calc
    import atd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        mode,
    output logic [WAY_W-1:0]  way,
    output logic              mode_ok
);
    logic [WAY_W-1:0] low_bits;
    logic [WAY_W-1:0] high_bits;
    logic [1:0]       resid;

    assign low_bits  = addr[GRAN_LG +: WAY_W];
    assign high_bits = addr[XOR_LSB +: WAY_W];
    assign resid     = mod3_of(addr[ADDR_W-1:GRAN_LG]);

    always_comb begin
        way     = '0;
        mode_ok = 1'b1;
        case (way_mode_e'(mode))
            WAY_DIRECT: way = low_bits;
            WAY_XOR:    way = low_bits ^ high_bits;
            WAY_MOD3:   way = WAY_W'({addr[GRAN_LG], resid});
            default:    mode_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/atd_chan_remap.sv
module atd_chan_remap
    import atd_pkg::*;
(
    input  logic [CODE_W-1:0]   logical,
    input  logic                is_write,
    input  logic                lockstep,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [MAP_BITS-1:0] rd_map,
    input  logic [MAP_BITS-1:0] wr_map,
    output logic [CODE_W-1:0]   phys
);
    localparam int PAD_W = (1 << CODE_W) * MAP_W;

    logic [PAD_W-1:0] map_pad;
    logic [MAP_W-1:0] field;
    logic             mirror_pick;

    assign map_pad     = is_write ? PAD_W'(wr_map) : PAD_W'(rd_map);
    assign field       = map_pad[MAP_W * int'(logical) +: MAP_W];
    assign mirror_pick = addr[MIR_B2] ^ addr[MIR_B1] ^ addr[MIR_B0];

    always_comb begin
        phys = logical;
        if (!lockstep && (int'(logical) < NCHAN)) begin
            case (field)
                3'd1: phys = CODE_W'(0);
                3'd2: phys = CODE_W'(1);
                3'd4: phys = CODE_W'(2);
                3'd5: phys = CODE_W'(0);
                3'd6: phys = CODE_W'(1);
                3'd3: if (!is_write) phys = CODE_W'(mirror_pick);
                default: phys = logical;
            endcase
        end
    end
endmodule

// File: rtl/addr_target_decoder.sv
module addr_target_decoder
    import atd_pkg::*;
#(
    parameter int N_RULES = 8,
    parameter int IDX_W   = $clog2(N_RULES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic                cfg_enable,
    input  logic [BLK_W-1:0]    cfg_limit,
    input  logic [1:0]          cfg_mode,
    input  logic [LIST_W-1:0]   cfg_list,
    input  logic                ctl_chan_level,
    input  logic                ctl_lockstep,
    input  logic [MAP_BITS-1:0] ctl_rd_map,
    input  logic [MAP_BITS-1:0] ctl_wr_map,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_write,
    output logic                rsp_valid,
    output logic                rsp_miss,
    output logic [CODE_W-1:0]   rsp_target
);
    rule_t             wr_rule;
    logic              bank_hit;
    rule_t             hit_rule;
    logic [WAY_W-1:0]  way;
    logic              mode_ok;
    logic [CODE_W-1:0] slot_code;
    logic [CODE_W-1:0] phys;
    rsp_t              rsp_d, rsp_q;

    assign wr_rule = '{en: cfg_enable, limit: cfg_limit, mode: cfg_mode, list: cfg_list};

    atd_rule_bank #(.N_RULES(N_RULES), .IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_rule  (wr_rule),
        .blk      (req_addr[ADDR_W-1:GRAN_LG]),
        .hit      (bank_hit),
        .hit_rule (hit_rule)
    );

    atd_way_calc u_way (
        .addr    (req_addr),
        .mode    (hit_rule.mode),
        .way     (way),
        .mode_ok (mode_ok)
    );

    assign slot_code = hit_rule.list[SLOT_W * int'(way) +: CODE_W];

    atd_chan_remap u_remap (
        .logical  (slot_code),
        .is_write (req_write),
        .lockstep (ctl_lockstep),
        .addr     (req_addr),
        .rd_map   (ctl_rd_map),
        .wr_map   (ctl_wr_map),
        .phys     (phys)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            if (!bank_hit || !mode_ok) begin
                rsp_d.miss = 1'b1;
            end else if (ctl_chan_level) begin
                rsp_d.target = phys;
            end else if (slot_code == CODE_W'(1)) begin
                rsp_d.target = CODE_W'(0);
            end else if (slot_code == CODE_W'(2)) begin
                rsp_d.target = CODE_W'(1);
            end else begin
                rsp_d.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_miss   = rsp_q.miss;
    assign rsp_target = rsp_q.target;

    assert_rsp_follows_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_no_rule_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !bank_hit) |=> rsp_miss);

    assert_rsvd_mode_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bank_hit && hit_rule.mode == 2'd3) |=> rsp_miss);

    assert_mod3_way_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bank_hit && hit_rule.mode == 2'd2) |-> (way[1:0] != 2'd3));

    assert_socket_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ctl_chan_level) |=> (rsp_miss || rsp_target <= CODE_W'(1)));

    assert_lockstep_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ctl_chan_level && ctl_lockstep && bank_hit && mode_ok)
        |=> (!rsp_miss && rsp_target == $past(slot_code)));
endmodule

// File: tb/sim_addr_target_decoder.sv
module sim_addr_target_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic        cfg_enable;
    logic [33:0] cfg_limit;
    logic [1:0]  cfg_mode;
    logic [31:0] cfg_list;
    logic        ctl_chan_level;
    logic        ctl_lockstep;
    logic [8:0]  ctl_rd_map;
    logic [8:0]  ctl_wr_map;
    logic        req_valid;
    logic [39:0] req_addr;
    logic        req_write;
    logic        rsp_valid;
    logic        rsp_miss;
    logic [1:0]  rsp_target;

    int n_checks = 0;
    int n_errors = 0;

    logic        m_en   [8];
    logic [33:0] m_lim  [8];
    logic [1:0]  m_mode [8];
    logic [31:0] m_list [8];
    string       mdl_tag;

    always #5 clk = ~clk;

    addr_target_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_enable(cfg_enable), .cfg_limit(cfg_limit), .cfg_mode(cfg_mode),
        .cfg_list(cfg_list), .ctl_chan_level(ctl_chan_level),
        .ctl_lockstep(ctl_lockstep), .ctl_rd_map(ctl_rd_map),
        .ctl_wr_map(ctl_wr_map), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss),
        .rsp_target(rsp_target)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // Called at a negative edge; leaves at a negative edge.
    task automatic program_rule(input int idx, input logic en, input logic [33:0] lim,
                                input logic [1:0] mode, input logic [31:0] list);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_enable = en;
        cfg_limit = lim; cfg_mode = mode; cfg_list = list;
        m_en[idx] = en; m_lim[idx] = lim; m_mode[idx] = mode; m_list[idx] = list;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input string tag, input logic [39:0] a, input logic wr,
                          input logic exp_miss, input logic [1:0] exp_tgt);
        req_valid = 1'b1; req_addr = a; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " miss"}, 32'(rsp_miss), 32'(exp_miss));
        if (!exp_miss) chk({tag, " target"}, 32'(rsp_target), 32'(exp_tgt));
    endtask

    function automatic logic [2:0] model(input logic [39:0] a, input logic wr,
                                         input logic cl, input logic lk,
                                         input logic [8:0] rm, input logic [8:0] wm);
        logic [33:0] b;
        logic [33:0] prev;
        int          sel;
        logic [2:0]  way;
        logic [1:0]  code;
        logic [2:0]  f;
        logic [1:0]  ph;
        b = a[39:6];
        prev = '0;
        sel = -1;
        for (int i = 0; i < 8; i++) begin
            if (sel < 0 && m_en[i] && b >= prev && b < m_lim[i]) sel = i;
            prev = m_lim[i];
        end
        if (sel < 0) begin mdl_tag = "R1/R2 nomatch"; return 3'b100; end
        case (m_mode[sel])
            2'd0: begin way = a[8:6]; mdl_tag = "R3"; end
            2'd1: begin way = a[8:6] ^ a[18:16]; mdl_tag = "R4"; end
            2'd2: begin way = {a[6], 2'(b % 34'd3)}; mdl_tag = "R5"; end
            default: begin mdl_tag = "R6"; return 3'b100; end
        endcase
        code = m_list[sel][4*int'(way) +: 2];
        if (!cl) begin
            mdl_tag = {mdl_tag, " R7 R8"};
            if (code == 2'd1) return 3'b000;
            if (code == 2'd2) return 3'b001;
            return 3'b100;
        end
        ph = code;
        if (lk) mdl_tag = {mdl_tag, " R11"};
        else if (code < 2'd3) begin
            f = wr ? wm[3*int'(code) +: 3] : rm[3*int'(code) +: 3];
            mdl_tag = {mdl_tag, " R9"};
            case (f)
                3'd1: ph = 2'd0;
                3'd2: ph = 2'd1;
                3'd4: ph = 2'd2;
                3'd5: ph = 2'd0;
                3'd6: ph = 2'd1;
                3'd3: begin
                    mdl_tag = {mdl_tag, " R10"};
                    if (!wr) ph = {1'b0, a[24] ^ a[12] ^ a[6]};
                end
                default: ph = code;
            endcase
        end
        return {1'b0, ph};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL R12 watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [2:0] e;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) begin
            m_en[i] = 1'b0; m_lim[i] = '0; m_mode[i] = '0; m_list[i] = '0;
        end
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_enable = 1'b0; cfg_limit = '0;
        cfg_mode = '0; cfg_list = '0; ctl_chan_level = 1'b0; ctl_lockstep = 1'b0;
        ctl_rd_map = '0; ctl_wr_map = '0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset valid", 32'(rsp_valid), 32'd0);
        chk("R12 reset miss", 32'(rsp_miss), 32'd0);

        // R2: empty bank after reset
        lookup("R2 empty bank", 40'h12_3456_7880, 1'b0, 1'b1, 2'd0);
        @(negedge clk);
        chk("R12 idle cycle", 32'(rsp_valid), 32'd0);

        // R13/R7/R8: socket decode
        program_rule(0, 1'b1, 34'd16, 2'd0, 32'h7654_3210);
        lookup("R13 R8 code1", 40'h40, 1'b0, 1'b0, 2'd0);
        lookup("R7 R8 code2", 40'h80, 1'b0, 1'b0, 2'd1);
        lookup("R8 code3 miss", 40'hC0, 1'b0, 1'b1, 2'd0);
        lookup("R8 code0 miss", 40'h0, 1'b0, 1'b1, 2'd0);

        // R1: boundaries
        program_rule(1, 1'b1, 34'd32, 2'd0, 32'h2222_2222);
        lookup("R1 below limit", 40'h340, 1'b0, 1'b0, 2'd0);
        lookup("R1 at limit", 40'h400, 1'b0, 1'b0, 2'd1);
        lookup("R1 past last", 40'h800, 1'b0, 1'b1, 2'd0);
        program_rule(1, 1'b0, 34'd32, 2'd0, 32'h2222_2222);
        lookup("R2 disabled rule", 40'h400, 1'b0, 1'b1, 2'd0);
        program_rule(2, 1'b1, 34'd48, 2'd0, 32'h1111_1111);
        lookup("R1 base from disabled", 40'h400, 1'b0, 1'b1, 2'd0);
        lookup("R1 rule2 range", 40'h800, 1'b0, 1'b0, 2'd0);

        // R3/R4/R5/R6 at channel level under lockstep (target = slot code)
        program_rule(2, 1'b0, 34'd0, 2'd0, 32'h0);
        program_rule(1, 1'b0, 34'd0, 2'd0, 32'h0);
        ctl_chan_level = 1'b1; ctl_lockstep = 1'b1;
        program_rule(0, 1'b1, 34'h3_FFFF_FFFF, 2'd0, 32'h7654_3210);
        lookup("R3 direct", 40'h0_0003_0140, 1'b0, 1'b0, 2'd1);
        program_rule(0, 1'b1, 34'h3_FFFF_FFFF, 2'd1, 32'h7654_3210);
        lookup("R4 xor", 40'h0_0003_0140, 1'b0, 1'b0, 2'd2);
        program_rule(0, 1'b1, 34'h3_FFFF_FFFF, 2'd2, 32'h7654_3210);
        lookup("R5 mod3 low", 40'h1C0, 1'b0, 1'b0, 2'd1);
        lookup("R5 mod3 high", 40'hFF_FFFF_FF80, 1'b0, 1'b0, 2'd2);
        program_rule(0, 1'b1, 34'h3_FFFF_FFFF, 2'd3, 32'h7654_3210);
        lookup("R6 reserved mode", 40'h40, 1'b0, 1'b1, 2'd0);

        // R9 mapper codes
        program_rule(0, 1'b1, 34'h3_FFFF_FFFF, 2'd0, 32'h7654_3210);
        ctl_lockstep = 1'b0;
        ctl_rd_map = {3'd6, 3'd5, 3'd4};
        lookup("R9 code4", 40'h0, 1'b0, 1'b0, 2'd2);
        lookup("R9 code5", 40'h40, 1'b0, 1'b0, 2'd0);
        lookup("R9 code6", 40'h80, 1'b0, 1'b0, 2'd1);
        lookup("R9 logical3 kept", 40'hC0, 1'b0, 1'b0, 2'd3);

        // R10 mirror
        ctl_rd_map = {3'd0, 3'd3, 3'd0};
        ctl_wr_map = {3'd0, 3'd3, 3'd0};
        lookup("R10 read parity1", 40'h40, 1'b0, 1'b0, 2'd1);
        lookup("R10 read parity0", 40'h1040, 1'b0, 1'b0, 2'd0);
        lookup("R10 read parity3b", 40'h100_0040, 1'b0, 1'b0, 2'd0);
        lookup("R10 write kept", 40'h1040, 1'b1, 1'b0, 2'd1);

        // R11 lockstep bypass
        ctl_lockstep = 1'b1;
        ctl_rd_map = {3'd4, 3'd4, 3'd4};
        lookup("R11 lockstep", 40'h40, 1'b0, 1'b0, 2'd1);

        // Random rounds checked against the model
        for (int round = 0; round < 4; round++) begin
            logic [33:0] acc;
            acc = '0;
            for (int i = 0; i < 8; i++) begin
                int m;
                logic [1:0] md;
                m = int'($urandom_range(0, 9));
                md = (m < 3) ? 2'd0 : (m < 6) ? 2'd1 : (m < 9) ? 2'd2 : 2'd3;
                acc = acc + 34'($urandom);
                program_rule(i, ($urandom_range(0, 7) != 0), acc, md, $urandom);
            end
            for (int k = 0; k < 500; k++) begin
                logic [39:0] a;
                logic        w;
                a = {8'($urandom), $urandom};
                w = 1'($urandom);
                ctl_chan_level = 1'($urandom);
                ctl_lockstep   = ($urandom_range(0, 3) == 0);
                ctl_rd_map     = 9'($urandom);
                ctl_wr_map     = 9'($urandom);
                e = model(a, w, ctl_chan_level, ctl_lockstep, ctl_rd_map, ctl_wr_map);
                lookup({"rand ", mdl_tag}, a, w, e[2], e[1:0]);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule